// File: doc/BRIEF.md
# Cascaded Match Priority Output Unit

This block is one device slice in a vertical stack of content-addressable memory devices. It keeps the outcome of the most recent compare, works out whether it is the responder with the highest priority in the stack, and drives the shared page:active address bus. A match flag and a full flag each pass from one device to the next in a chain. An open-drain multiple-match line is shared by all devices. The matching array itself is outside the block and appears only as input signals: the local hit, the multiple hit, the hit address, the full indication and the next free address.

A device takes part in a cycle when either of its two active-low chip selects is low. It also takes part when its device-select register holds its own page number and the active-low enable bit of that register is low. A compare on a device that is not selected wipes out any match it stored earlier. A read or write cycle sets the active address to the location accessed. A write to the next free location sets it to the free address. The bus value follows the internal state only on clock edges where chip enable is high, and it stays frozen while chip enable is low.

Top module: `casc_match_slice`

## Requirements
- R1: The device is selected when `cs1_n` is 0, or `cs2_n` is 0, or when `dsel_val` equals `page_id` and `dsel_en_n` is 0. Otherwise it is not selected.
- R2: On a clock edge with `op`=1 (compare) and the device selected, the stored match becomes `core_hit`, the stored multiple hit becomes `core_hit & core_multi`, and the stored address becomes `core_hit_addr`.
- R3: On a compare edge with the device not selected, the stored match and multiple hit are cleared, so `mf_n` then follows `mi_n` alone.
- R4: `mf_n` is 0 whenever the stored match is 1 or `mi_n` is 0, and 1 otherwise.
- R5: `core_full` is registered on every edge. `ff_n` is 0 exactly when that registered bit is 1 and `fi_n` is 0.
- R6: `mm_pull` is 1 when the stored multiple hit is 1, or when the stored match is 1 and `mi_n` is 0.
- R7: After a compare, a device with a stored match and `mi_n`=1 drives `pa_aa` = {`page_id`, match address}. A device whose `mi_n` is 0 never drives.
- R8: After a compare, a device with `last_dev`=1, `mi_n`=1 and no stored match drives `pa_aa` as all ones.
- R9: On an edge with `op`=2 (access), a selected device loads `acc_addr` as the active address and becomes the bus owner. On an edge with `op`=3 (write to next free location) it loads `core_free_addr` instead. A device that is not selected on an access edge gives up bus ownership.
- R10: `pa_oe` is 0 whenever `oe_n` is 1. When `oe_n` is 0, `pa_oe` equals the latched drive decision.
- R11: The latched `pa_aa` value and the latched drive decision load the state from before the edge, but only on clock edges where `ce_n` is 1. On edges where `ce_n` is 0 both hold their values. After reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Cycle type: 0 idle, 1 compare, 2 access, 3 write to next free location |
| cs1_n | input | 1 | Chip select one, active low |
| cs2_n | input | 1 | Chip select two, active low |
| dsel_val | input | PAGE_W | Device-select register value |
| dsel_en_n | input | 1 | Device-select enable bit, active low |
| page_id | input | PAGE_W | Page number of this device |
| last_dev | input | 1 | This device has the lowest priority in the stack |
| core_hit | input | 1 | Local array reports a hit |
| core_multi | input | 1 | Local array reports two or more hits |
| core_hit_addr | input | ADDR_W | Address of the local hit with the highest priority |
| core_full | input | 1 | Local array has no free location |
| core_free_addr | input | ADDR_W | Next free location in the local array |
| acc_addr | input | ADDR_W | Address of a random-access cycle |
| mi_n | input | 1 | Match-in from the neighbour with higher priority, active low |
| fi_n | input | 1 | Full-in from the neighbour with higher priority, active low |
| ce_n | input | 1 | Chip enable, active low; bus value frozen while low |
| oe_n | input | 1 | Output enable, active low |
| mf_n | output | 1 | Match-out to the neighbour with lower priority |
| ff_n | output | 1 | Full-out to the neighbour with lower priority |
| mm_pull | output | 1 | Pull-down enable for the shared open-drain multiple-match line |
| pa_aa | output | PAGE_W+ADDR_W | Page:active address bus value |
| pa_oe | output | 1 | Tri-state enable for `pa_aa` |

## Verification
The assertions assume three things about the inputs. The `op` code is one of its four values on every edge. `mi_n` and `fi_n` come from a neighbour that behaves consistently. Nothing treats `core_multi` as meaningful without `core_hit`. The random stimulus draws `op` from the full 2-bit range and biases the selection inputs so that selected and deselected compares both occur often. It also toggles `ce_n` and `oe_n` independently of the cycle type, so the frozen-bus and high-impedance cases are covered. Directed sequences cover selection through the device-select register alone, clearing of a match by a deselected compare, all ones from the last device, and holding the bus while chip enable is low.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_CMP  = 2'd1,
    OP_ACC  = 2'd2,
    OP_FREE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_MATCH = 2'd1,
    SRC_RAND  = 2'd2,
    SRC_FREE  = 2'd3
  } src_e;
endpackage

// File: rtl/casc_select.sv
module casc_select #(
  parameter int PAGE_W = 4
) (
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic [PAGE_W-1:0] dsel_val,
  input  logic              dsel_en_n,
  input  logic [PAGE_W-1:0] page_id,
  output logic              sel
);
  logic reg_hit;

  // Register path selects only when it names this page and its enable is low
  always_comb begin
    reg_hit = (dsel_val == page_id) && !dsel_en_n;
    sel     = !cs1_n || !cs2_n || reg_hit;
  end

  // R1: a low chip select always selects the device
  always_comb begin
    if (!cs1_n || !cs2_n) assert_cs_sel_R1: assert (sel);
  end
endmodule

// File: rtl/casc_state.sv
module casc_state
  import casc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic              sel,
  input  logic              core_hit,
  input  logic              core_multi,
  input  logic [ADDR_W-1:0] core_hit_addr,
  input  logic              core_full,
  input  logic [ADDR_W-1:0] core_free_addr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              match_q,
  output logic              multi_q,
  output logic              full_q,
  output logic              own_q,
  output src_e              src_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      full_q  <= 1'b0;
      own_q   <= 1'b0;
      src_q   <= SRC_NONE;
      addr_q  <= '0;
    end else begin
      full_q <= core_full;
      unique case (op)
        OP_CMP: begin
          // a deselected compare wipes any earlier positive result
          match_q <= sel && core_hit;
          multi_q <= sel && core_hit && core_multi;
          addr_q  <= core_hit_addr;
          src_q   <= SRC_MATCH;
        end
        OP_ACC, OP_FREE: begin
          own_q <= sel;
          if (sel) begin
            addr_q <= (op == OP_ACC) ? acc_addr : core_free_addr;
            src_q  <= (op == OP_ACC) ? SRC_RAND : SRC_FREE;
          end else begin
            src_q  <= SRC_RAND;
          end
        end
        default: ;
      endcase
    end
  end

  assert_cmp_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP && !sel) |=> (!match_q && !multi_q));

  assert_cmp_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP && sel && core_hit) |=> (match_q && addr_q == $past(core_hit_addr)));

  assert_access_own_R9: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACC && sel) |=> (own_q && src_q == SRC_RAND && addr_q == $past(acc_addr)));
endmodule

// File: rtl/casc_chain.sv
module casc_chain (
  input  logic clk,
  input  logic rst,
  input  logic match_q,
  input  logic multi_q,
  input  logic full_q,
  input  logic mi_n,
  input  logic fi_n,
  output logic mf_n,
  output logic ff_n,
  output logic mm_pull
);
  always_comb begin
    mf_n    = !(match_q || !mi_n);
    ff_n    = !(full_q && !fi_n);
    mm_pull = multi_q || (match_q && !mi_n);
  end

  assert_mf_pass_R4: assert property (@(posedge clk) disable iff (rst)
    !mi_n |-> !mf_n);

  assert_mm_upstream_R6: assert property (@(posedge clk) disable iff (rst)
    (match_q && !mi_n) |-> mm_pull);

  assert_ff_open_R5: assert property (@(posedge clk) disable iff (rst)
    fi_n |-> ff_n);
endmodule

// File: rtl/casc_bus.sv
module casc_bus
  import casc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 8,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              mi_n,
  input  logic              last_dev,
  input  logic [PAGE_W-1:0] page_id,
  input  src_e              src_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              match_q,
  input  logic              own_q,
  output logic [BUS_W-1:0]  pa_aa,
  output logic              pa_oe
);
  logic [BUS_W-1:0] bus_d, bus_q;
  logic             drv_d, drv_q;

  always_comb begin
    bus_d = {page_id, addr_q};
    drv_d = 1'b0;
    unique case (src_q)
      SRC_MATCH: begin
        if (match_q && mi_n) begin
          drv_d = 1'b1;
        end else if (last_dev && mi_n && !match_q) begin
          drv_d = 1'b1;
          bus_d = '1;
        end
      end
      SRC_RAND, SRC_FREE: drv_d = own_q;
      default: drv_d = 1'b0;
    endcase
  end

  // value moves only while chip enable is high
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      drv_q <= 1'b0;
    end else if (ce_n) begin
      bus_q <= bus_d;
      drv_q <= drv_d;
    end
  end

  assign pa_aa = bus_q;
  assign pa_oe = !oe_n && drv_q;

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !ce_n |=> ($stable(bus_q) && $stable(drv_q)));

  assert_lower_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (ce_n && src_q == SRC_MATCH && !mi_n) |=> !drv_q);

  assert_ones_only_last_R8: assert property (@(posedge clk) disable iff (rst)
    (ce_n && src_q == SRC_MATCH && !last_dev && !match_q) |=> !drv_q);

  assert_oe_hiz_R10: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !pa_oe);
endmodule

// File: rtl/casc_match_slice.sv
module casc_match_slice
  import casc_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int ADDR_W = 8,
  localparam int BUS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic [PAGE_W-1:0] dsel_val,
  input  logic              dsel_en_n,
  input  logic [PAGE_W-1:0] page_id,
  input  logic              last_dev,
  input  logic              core_hit,
  input  logic              core_multi,
  input  logic [ADDR_W-1:0] core_hit_addr,
  input  logic              core_full,
  input  logic [ADDR_W-1:0] core_free_addr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              mi_n,
  input  logic              fi_n,
  input  logic              ce_n,
  input  logic              oe_n,
  output logic              mf_n,
  output logic              ff_n,
  output logic              mm_pull,
  output logic [BUS_W-1:0]  pa_aa,
  output logic              pa_oe
);
  logic              sel;
  logic              match_q, multi_q, full_q, own_q;
  src_e              src_q;
  logic [ADDR_W-1:0] addr_q;
  op_e               op_t;

  assign op_t = op_e'(op);

  casc_select #(.PAGE_W(PAGE_W)) u_sel (
    .cs1_n(cs1_n), .cs2_n(cs2_n), .dsel_val(dsel_val),
    .dsel_en_n(dsel_en_n), .page_id(page_id), .sel(sel)
  );

  casc_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst(rst), .op(op_t), .sel(sel),
    .core_hit(core_hit), .core_multi(core_multi), .core_hit_addr(core_hit_addr),
    .core_full(core_full), .core_free_addr(core_free_addr), .acc_addr(acc_addr),
    .match_q(match_q), .multi_q(multi_q), .full_q(full_q), .own_q(own_q),
    .src_q(src_q), .addr_q(addr_q)
  );

  casc_chain u_chain (
    .clk(clk), .rst(rst), .match_q(match_q), .multi_q(multi_q), .full_q(full_q),
    .mi_n(mi_n), .fi_n(fi_n), .mf_n(mf_n), .ff_n(ff_n), .mm_pull(mm_pull)
  );

  casc_bus #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .mi_n(mi_n),
    .last_dev(last_dev), .page_id(page_id), .src_q(src_q), .addr_q(addr_q),
    .match_q(match_q), .own_q(own_q), .pa_aa(pa_aa), .pa_oe(pa_oe)
  );
endmodule

// File: tb/casc_match_slice_tb.sv
module casc_match_slice_tb;
  localparam int PAGE_W = 4;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = PAGE_W + ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] op = 2'd0;
  logic cs1_n = 1'b1, cs2_n = 1'b1, dsel_en_n = 1'b1, last_dev = 1'b0;
  logic [PAGE_W-1:0] dsel_val = '0, page_id = 4'd5;
  logic core_hit = 1'b0, core_multi = 1'b0, core_full = 1'b0;
  logic [ADDR_W-1:0] core_hit_addr = '0, core_free_addr = '0, acc_addr = '0;
  logic mi_n = 1'b1, fi_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
  logic mf_n, ff_n, mm_pull, pa_oe;
  logic [BUS_W-1:0] pa_aa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit m_match, m_multi, m_full, m_own, m_drv;
  int m_src;
  logic [ADDR_W-1:0] m_addr;
  logic [BUS_W-1:0]  m_bus;

  always #10 clk = ~clk;

  casc_match_slice #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .op(op), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .dsel_val(dsel_val), .dsel_en_n(dsel_en_n), .page_id(page_id),
    .last_dev(last_dev), .core_hit(core_hit), .core_multi(core_multi),
    .core_hit_addr(core_hit_addr), .core_full(core_full),
    .core_free_addr(core_free_addr), .acc_addr(acc_addr), .mi_n(mi_n),
    .fi_n(fi_n), .ce_n(ce_n), .oe_n(oe_n), .mf_n(mf_n), .ff_n(ff_n),
    .mm_pull(mm_pull), .pa_aa(pa_aa), .pa_oe(pa_oe)
  );

  function automatic bit exp_sel();
    return !cs1_n || !cs2_n || (dsel_val == page_id && !dsel_en_n);
  endfunction

  task automatic chk(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_match = 0; m_multi = 0; m_full = 0; m_own = 0; m_drv = 0;
    m_src = 0; m_addr = '0; m_bus = '0;
  endtask

  task automatic model_edge();
    bit s;
    s = exp_sel();
    if (ce_n) begin
      m_bus = {page_id, m_addr};
      m_drv = 0;
      if (m_src == 1) begin
        if (m_match && mi_n) m_drv = 1;
        else if (last_dev && mi_n && !m_match) begin m_drv = 1; m_bus = '1; end
      end else if (m_src >= 2) m_drv = m_own;
    end
    m_full = core_full;
    case (op)
      2'd1: begin
        m_match = s && core_hit;
        m_multi = s && core_hit && core_multi;
        m_addr  = core_hit_addr;
        m_src   = 1;
      end
      2'd2, 2'd3: begin
        m_own = s;
        if (s) begin
          m_addr = (op == 2'd2) ? acc_addr : core_free_addr;
          m_src  = (op == 2'd2) ? 2 : 3;
        end else m_src = 2;
      end
      default: ;
    endcase
  endtask

  task automatic check_all();
    chk("R4 mf_n", BUS_W'(mf_n), BUS_W'(!(m_match || !mi_n)));
    chk("R5 ff_n", BUS_W'(ff_n), BUS_W'(!(m_full && !fi_n)));
    chk("R6 mm_pull", BUS_W'(mm_pull), BUS_W'(m_multi || (m_match && !mi_n)));
    chk("R10 pa_oe", BUS_W'(pa_oe), BUS_W'(!oe_n && m_drv));
    chk("R11 R7 R8 R9 pa_aa", pa_aa, m_bus);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #2;
    check_all();
  endtask

  task automatic idle_in();
    op = 2'd0; core_hit = 0; core_multi = 0;
  endtask

  task automatic randomize_in();
    op         = 2'($urandom_range(0, 3));
    cs1_n      = ($urandom_range(0, 3) != 0);
    cs2_n      = ($urandom_range(0, 3) != 0);
    dsel_en_n  = $urandom_range(0, 1);
    dsel_val   = ($urandom_range(0, 1) != 0) ? page_id : PAGE_W'($urandom);
    last_dev   = $urandom_range(0, 1);
    core_hit   = $urandom_range(0, 1);
    core_multi = $urandom_range(0, 1);
    core_full  = $urandom_range(0, 1);
    core_hit_addr  = ADDR_W'($urandom);
    core_free_addr = ADDR_W'($urandom);
    acc_addr   = ADDR_W'($urandom);
    mi_n       = $urandom_range(0, 1);
    fi_n       = $urandom_range(0, 1);
    ce_n       = ($urandom_range(0, 9) < 7);
    oe_n       = ($urandom_range(0, 3) == 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h1CA7_5EED));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    // reset state (R11): bus zero, not driving; flags idle
    oe_n = 0;
    #1;
    chk("R11 reset pa_aa", pa_aa, '0);
    chk("R10 reset pa_oe", BUS_W'(pa_oe), '0);
    chk("R4 reset mf_n", BUS_W'(mf_n), BUS_W'(1));
    chk("R6 reset mm_pull", BUS_W'(mm_pull), '0);

    // R1: selected only through the device-select register
    cs1_n = 1; cs2_n = 1; dsel_val = page_id; dsel_en_n = 0;
    op = 2'd1; core_hit = 1; core_hit_addr = 8'hA7; mi_n = 1; ce_n = 1; last_dev = 0;
    step();
    chk("R1 R2 match via dsel mf_n", BUS_W'(mf_n), '0);
    idle_in(); step();
    chk("R7 top responder drives", BUS_W'(pa_oe), BUS_W'(1));
    chk("R7 match address on bus", pa_aa, {page_id, 8'hA7});

    // R3: deselected compare clears the match
    dsel_en_n = 1; op = 2'd1; core_hit = 1;
    step();
    chk("R3 cleared mf_n", BUS_W'(mf_n), BUS_W'(1));
    idle_in();

    // R8: last device, nothing matched, drives all ones
    last_dev = 1; step();
    chk("R8 all ones", pa_aa, '1);
    chk("R8 drives", BUS_W'(pa_oe), BUS_W'(1));

    // R9 access then R11 hold while chip enable low
    cs1_n = 0; op = 2'd2; acc_addr = 8'h3C; step();
    idle_in(); step();
    chk("R9 access address", pa_aa, {page_id, 8'h3C});
    ce_n = 0; op = 2'd3; core_free_addr = 8'h91; step();
    idle_in(); step(); step();
    chk("R11 held while ce_n low", pa_aa, {page_id, 8'h3C});
    ce_n = 1; step();
    chk("R9 free address after release", pa_aa, {page_id, 8'h91});
    oe_n = 1; #1;
    chk("R10 oe_n high hiz", BUS_W'(pa_oe), '0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      randomize_in();
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule